// File: doc/BRIEF.md
# Privileged Interrupt Selector

This block decides, on every clock, whether a hart should take an interrupt now, and which one. It receives a vector of pending interrupt lines, already qualified by the per-line enables. It also receives a per-line delegation mask, the current privilege level, and the two global interrupt-enable bits for machine and supervisor level. From these it produces a registered take strobe and the cause word that a trap-entry unit would record.

Selection has two tiers. Lines that are not delegated belong to machine level. They are considered first, under the machine enable rule. Delegated lines are considered only when no machine-level candidate survives, and then under the supervisor enable rule. Within the surviving tier the lowest-numbered line wins. A small control module resolves the two enable conditions into a strobe struct. A datapath module masks the tiers, encodes the winner and registers the result. A thin top joins the two.

Top module: `irq_sel_top`

## Requirements
- R1: While reset (`rstN` low, asynchronous) is asserted, `takeIrq` is 0 and `causeOut` is all zeros.
- R2: Machine-level candidates are enabled when `privLevel` is below 3 (user = 0, supervisor = 1), or when `privLevel` is 3 (machine) and `mieBit` is 1.
- R3: Supervisor-level (delegated) candidates are enabled when `privLevel` is 0, or when `privLevel` is 1 and `sieBit` is 1; at machine level they are never taken.
- R4: The first tier is `pendingIn & ~delegMask`, gated to zero when the machine enable of R2 is false.
- R5: Only when the first tier is zero does the candidate set become `pendingIn & delegMask`, gated by the supervisor enable of R3; an enabled non-delegated line therefore wins over any delegated line, whatever its index.
- R6: The selected interrupt is the index of the lowest set bit of the final candidate set (a trailing-zero count).
- R7: When an interrupt is taken, `causeOut` bit XLEN-1 is 1, bits log2(XLEN)-1..0 hold the selected index, and all other bits are 0.
- R8: When the final candidate set is empty, `takeIrq` is 0 and `causeOut` is all zeros.
- R9: Outputs are registered: they reflect the inputs present at the previous rising clock edge and do not change between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| pendingIn | input | XLEN | Pending interrupt lines, already masked by per-line enables |
| delegMask | input | XLEN | Per-line delegation to supervisor level |
| privLevel | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| mieBit | input | 1 | Global machine interrupt enable |
| sieBit | input | 1 | Global supervisor interrupt enable |
| takeIrq | output | 1 | Registered strobe: an interrupt is to be taken |
| causeOut | output | XLEN | Registered cause: interrupt flag in MSB, index in low bits |

## Verification
The assertions take for granted that `privLevel` only carries the three legal codes 0, 1 and 3. They also take for granted that the inputs are stable around the rising edge, so that the value seen one cycle back is the one the output registers captured. The bench drives all inputs on the falling edge and draws privilege only from the three legal codes. This keeps the reserved code 2 out of every vector, both in the hand-written table and in the sweep over every privilege and enable combination.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_e;

  // Strobes handed from the enable-resolution control to the datapath.
  typedef struct packed {
    logic mEnable;  // machine tier may be considered
    logic sEnable;  // delegated tier may be considered
  } tierCtrl_t;

endpackage

// File: rtl/irq_sel_ctrl.sv
module irq_sel_ctrl
  import irq_sel_pkg::*;
(
  input  logic [1:0] privLevel,
  input  logic       mieBit,
  input  logic       sieBit,
  output tierCtrl_t  ctrl
);

  logic belowMach;
  logic atMach;
  logic belowSuper;
  logic atSuper;

  always_comb begin
    belowMach  = (privLevel < PRIV_MACH);
    atMach     = (privLevel == PRIV_MACH);
    belowSuper = (privLevel < PRIV_SUPER);
    atSuper    = (privLevel == PRIV_SUPER);
  end

  // R2: machine tier open below M, or at M with the global enable set.
  // R3: delegated tier open below S, or at S with the global enable set.
  always_comb begin
    ctrl.mEnable = belowMach  | (atMach  & mieBit);
    ctrl.sEnable = belowSuper | (atSuper & sieBit);
  end

endmodule

// File: rtl/irq_sel_dp.sv
module irq_sel_dp
  import irq_sel_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [XLEN-1:0] pendingIn,
  input  logic [XLEN-1:0] delegMask,
  input  tierCtrl_t       ctrl,
  output logic            takeIrq,
  output logic [XLEN-1:0] causeOut
);

  localparam int IDX_W = $clog2(XLEN);

  logic [XLEN-1:0]  machSet;
  logic [XLEN-1:0]  superSet;
  logic [XLEN-1:0]  finalSet;
  logic             anyMach;
  logic             anyFinal;
  logic [IDX_W-1:0] winIdx;
  logic [XLEN-1:0]  causeNext;

  // R4 / R5: two-tier candidate selection.
  always_comb begin
    machSet  = pendingIn & ~delegMask & {XLEN{ctrl.mEnable}};
    superSet = pendingIn &  delegMask & {XLEN{ctrl.sEnable}};
    anyMach  = |machSet;
    finalSet = anyMach ? machSet : superSet;
    anyFinal = |finalSet;
  end

  // R6: trailing-zero count; scanning downward lets the lowest bit win.
  always_comb begin
    winIdx = '0;
    for (int i = XLEN - 1; i >= 0; i--) begin
      if (finalSet[i]) winIdx = IDX_W'(i);
    end
  end

  // R7 / R8: cause word assembly.
  always_comb begin
    causeNext = '0;
    if (anyFinal) begin
      causeNext[XLEN-1]    = 1'b1;
      causeNext[IDX_W-1:0] = winIdx;
    end
  end

  // R1 / R9: output register stage.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      takeIrq  <= 1'b0;
      causeOut <= '0;
    end else begin
      takeIrq  <= anyFinal;
      causeOut <= causeNext;
    end
  end

  AST_TAKE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> causeOut[XLEN-1]);  // R7

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !takeIrq |-> (causeOut == '0));  // R8

  AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> ((($past(pendingIn) >> causeOut[IDX_W-1:0]) & XLEN'(1)) != '0));  // R6

  AST_MACH_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (takeIrq && ((($past(delegMask) >> causeOut[IDX_W-1:0]) & XLEN'(1)) == '0))
      |-> $past(ctrl.mEnable));  // R4

  AST_SUPER_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (takeIrq && ((($past(delegMask) >> causeOut[IDX_W-1:0]) & XLEN'(1)) != '0))
      |-> $past(ctrl.sEnable));  // R3

  AST_DELEG_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (takeIrq && ((($past(delegMask) >> causeOut[IDX_W-1:0]) & XLEN'(1)) != '0))
      |-> (!$past(ctrl.mEnable) || (($past(pendingIn) & ~$past(delegMask)) == '0)));  // R5

endmodule

// File: rtl/irq_sel_top.sv
module irq_sel_top
  import irq_sel_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [XLEN-1:0] pendingIn,
  input  logic [XLEN-1:0] delegMask,
  input  logic [1:0]      privLevel,
  input  logic            mieBit,
  input  logic            sieBit,
  output logic            takeIrq,
  output logic [XLEN-1:0] causeOut
);

  tierCtrl_t tierCtrl;

  irq_sel_ctrl u_ctrl (
    .privLevel (privLevel),
    .mieBit    (mieBit),
    .sieBit    (sieBit),
    .ctrl      (tierCtrl)
  );

  irq_sel_dp #(.XLEN(XLEN)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .pendingIn (pendingIn),
    .delegMask (delegMask),
    .ctrl      (tierCtrl),
    .takeIrq   (takeIrq),
    .causeOut  (causeOut)
  );

endmodule

// File: tb/irq_sel_top_tb.sv
module irq_sel_top_tb;

  localparam int XLEN = 32;

  typedef struct packed {
    logic [31:0] pend;
    logic [31:0] deleg;
    logic [1:0]  priv;
    logic        mie;
    logic        sie;
    logic        take;
    logic [4:0]  idx;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{32'h00000080, 32'h00000000, 2'd3, 1'b1, 1'b0, 1'b1, 5'd7},   // R2 machine, enabled
    '{32'h00000080, 32'h00000000, 2'd3, 1'b0, 1'b0, 1'b0, 5'd0},   // R2 machine, disabled
    '{32'h00000080, 32'h00000000, 2'd1, 1'b0, 1'b0, 1'b1, 5'd7},   // R2 below machine
    '{32'h00000022, 32'h00000002, 2'd3, 1'b1, 1'b1, 1'b1, 5'd5},   // R5 non-delegated wins
    '{32'h00000002, 32'h00000002, 2'd3, 1'b1, 1'b1, 1'b0, 5'd0},   // R3 delegated at M
    '{32'h00000002, 32'h00000002, 2'd1, 1'b0, 1'b1, 1'b1, 5'd1},   // R3 at S, enabled
    '{32'h00000002, 32'h00000002, 2'd1, 1'b0, 1'b0, 1'b0, 5'd0},   // R3 at S, disabled
    '{32'h00000002, 32'h00000002, 2'd0, 1'b0, 1'b0, 1'b1, 5'd1},   // R3 below S
    '{32'h00000022, 32'h00000002, 2'd3, 1'b0, 1'b1, 1'b0, 5'd0},   // R4 gated tier, fallback closed
    '{32'h00000022, 32'h00000002, 2'd1, 1'b0, 1'b0, 1'b1, 5'd5},   // R5 tier one at S
    '{32'h80000001, 32'h00000000, 2'd0, 1'b0, 1'b0, 1'b1, 5'd0},   // R6 lowest bit
    '{32'h80000000, 32'h00000000, 2'd0, 1'b0, 1'b0, 1'b1, 5'd31},  // R7 top index
    '{32'h00000A00, 32'h00000A00, 2'd0, 1'b0, 1'b0, 1'b1, 5'd9},   // R6 within delegated tier
    '{32'h00000000, 32'hFFFFFFFF, 2'd0, 1'b1, 1'b1, 1'b0, 5'd0}    // R8 nothing pending
  };

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [XLEN-1:0] pendingIn = '0;
  logic [XLEN-1:0] delegMask = '0;
  logic [1:0]      privLevel = 2'd3;
  logic            mieBit = 1'b0;
  logic            sieBit = 1'b0;
  logic            takeIrq;
  logic [XLEN-1:0] causeOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_sel_top #(.XLEN(XLEN)) u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .pendingIn (pendingIn),
    .delegMask (delegMask),
    .privLevel (privLevel),
    .mieBit    (mieBit),
    .sieBit    (sieBit),
    .takeIrq   (takeIrq),
    .causeOut  (causeOut)
  );

  function automatic logic [XLEN:0] refModel(logic [31:0] p, logic [31:0] d,
                                             logic [1:0] pr, logic me, logic se);
    logic        mOn, sOn;
    logic [31:0] cand;
    logic [XLEN:0] res;
    mOn  = (pr < 2'd3) || (pr == 2'd3 && me);
    sOn  = (pr < 2'd1) || (pr == 2'd1 && se);
    cand = mOn ? (p & ~d) : 32'h0;
    if (cand == 32'h0) cand = sOn ? (p & d) : 32'h0;
    res = '0;
    for (int i = 0; i < 32; i++) begin
      if (cand[i]) begin
        res = {1'b1, 1'b1, 26'h0, 5'(i)};
        break;
      end
    end
    return res;
  endfunction

  task automatic checkOut(logic expTake, logic [XLEN-1:0] expCause, string what);
    checks++;
    if (takeIrq !== expTake || causeOut !== expCause) begin
      errors++;
      $display("FAIL %s: take=%0b cause=%h expected take=%0b cause=%h",
               what, takeIrq, causeOut, expTake, expCause);
    end
  endtask

  task automatic drive(logic [31:0] p, logic [31:0] d, logic [1:0] pr, logic me, logic se);
    @(negedge clk);
    pendingIn = p;
    delegMask = d;
    privLevel = pr;
    mieBit    = me;
    sieBit    = se;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [XLEN:0] r;
    // R1: reset state
    repeat (2) @(negedge clk);
    checkOut(1'b0, '0, "R1 reset idle");
    drive(32'h1, 32'h0, 2'd0, 1'b1, 1'b1);
    @(negedge clk);
    checkOut(1'b0, '0, "R1 held in reset with pending input");
    rstN = 1'b1;

    // Table walk (requirements named per row).
    for (int k = 0; k < NVEC; k++) begin
      drive(VECS[k].pend, VECS[k].deleg, VECS[k].priv, VECS[k].mie, VECS[k].sie);
      @(negedge clk);
      checkOut(VECS[k].take,
               VECS[k].take ? {1'b1, 26'h0, VECS[k].idx} : 32'h0,
               $sformatf("table row %0d (R2 R3 R4 R5 R6 R7 R8)", k));
    end

    // Sweep all legal privileges and enables against the bench model (R2, R3, R5, R6).
    for (int pi = 0; pi < 3; pi++) begin
      for (int me = 0; me < 2; me++) begin
        for (int se = 0; se < 2; se++) begin
          for (int k = 0; k < 8; k++) begin
            logic [1:0]  pr;
            logic [31:0] p, d;
            pr = (pi == 2) ? 2'd3 : 2'(pi);
            p  = (k == 7) ? 32'h0 : ((32'h9 << (k * 3)) ^ (32'(k) * 32'h01010101));
            d  = k[0] ? 32'h0000FFFF : 32'hF0F0F0F0;
            drive(p, d, pr, me[0], se[0]);
            @(negedge clk);
            r = refModel(p, d, pr, me[0], se[0]);
            checkOut(r[XLEN], r[XLEN-1:0],
                     $sformatf("sweep R2 R3 R5 R6 priv=%0d mie=%0d sie=%0d k=%0d", pr, me, se, k));
          end
        end
      end
    end

    // R9: output holds until the next rising edge, then follows.
    drive(32'h00000010, 32'h0, 2'd0, 1'b0, 1'b0);
    @(negedge clk);
    checkOut(1'b1, 32'h80000004, "R9 first value");
    drive(32'h00000100, 32'h0, 2'd0, 1'b0, 1'b0);
    #1;
    checkOut(1'b1, 32'h80000004, "R9 no change before edge");
    @(negedge clk);
    checkOut(1'b1, 32'h80000008, "R9 follows after edge");

    // R8: pending only on delegated lines at M is dropped.
    drive(32'hFFFF0000, 32'hFFFF0000, 2'd3, 1'b1, 1'b1);
    @(negedge clk);
    checkOut(1'b0, '0, "R8 empty final set");

    // R1: asynchronous reset while an interrupt is being reported.
    drive(32'h00000004, 32'h0, 2'd0, 1'b0, 1'b0);
    @(negedge clk);
    checkOut(1'b1, 32'h80000002, "R1 pre-reset take");
    rstN = 1'b0;
    #1;
    checkOut(1'b0, '0, "R1 async reset clears");
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkOut(1'b1, 32'h80000002, "R1 resumes after reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule